// File: doc/BRIEF.md
# I/Q Port Demultiplexer

This block sits at the input of a dual-channel transmit datapath. It takes signed or offset-binary I and Q samples, delivered either as two words per clock on two parallel ports or as one word per clock on a single shared port. It delivers aligned I and Q words on registered outputs, with a one-cycle valid strobe for each complete pair. In shared-port mode the port clock runs at twice the channel rate, so a pair takes two clocks.

In shared-port mode each word is steered by a select pin, whose polarity can be flipped. It can also be steered by an internal alternating phase, in which case the pin is ignored. A configuration bit sets which channel leads a pair. In dual-port mode the select pin is not used for steering and serves as the most significant bit of the second port.

A registered channel-rate clock output marks the pair phase and can be inverted. A mode change or a reset discards any half-received pair and restarts pairing.

Top module: `iq_port_demux`

## Requirements
- R1: While `rst` is high, `i_out`, `q_out`, `out_valid` and `rate_clk` are all driven to 0, and any half-received pair is discarded.
- R2: In dual-port mode (`cfg_one_port`=0), each clock edge with no mode change loads `i_out` from `port_a` and `q_out` from `{sel_b_msb, port_b_lo}`, with `out_valid`=1 after that edge.
- R3: In shared-port mode (`cfg_one_port`=1), the word on `port_a` goes to the I channel when the effective select is 1 and to Q when it is 0. `i_out`/`q_out` update together on the edge that samples the second word of a pair.
- R4: With `cfg_sel_inv`=1, the effective select is the inverse of `sel_b_msb`.
- R5: `cfg_q_first`=0 makes I the leading channel of a pair, and 1 makes Q lead. A trailing-channel word that arrives with no leading word pending is dropped, with no output change.
- R6: A second leading-channel word that arrives before the trailing one replaces the pending leading word.
- R7: With `cfg_sel_internal`=1 in shared-port mode, words alternate leading/trailing starting from the leading channel, and `sel_b_msb` is ignored.
- R8: With `cfg_unsigned`=1, the MSB of every input word is inverted (offset binary to two's complement) before it is stored. With 0, words pass unchanged.
- R9: After each edge, `rate_clk` equals X XOR `cfg_rclk_inv`. In shared-port mode X is 1 when the next word expected is the leading one and 0 otherwise. In dual-port mode X is 1.
- R10: The edge on which `cfg_one_port` differs from its value at the previous edge emits nothing, ignores the data and discards a pending leading word.
- R11: `out_valid` is high for exactly one cycle per emitted pair, and `i_out`/`q_out` hold their values whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (twice channel rate in shared-port mode) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_one_port | input | 1 | 0 dual-port, 1 shared single port |
| cfg_q_first | input | 1 | 0 I leads a pair, 1 Q leads |
| cfg_sel_inv | input | 1 | Invert the select pin |
| cfg_sel_internal | input | 1 | Steer by internal alternating phase |
| cfg_unsigned | input | 1 | Input words are offset binary |
| cfg_rclk_inv | input | 1 | Invert the channel-rate clock output |
| port_a | input | DW | Shared-port word, or I word in dual-port mode |
| port_b_lo | input | DW-1 | Lower bits of the Q word in dual-port mode |
| sel_b_msb | input | 1 | Channel select, or MSB of the Q word in dual-port mode |
| i_out | output | DW | Aligned I sample |
| q_out | output | DW | Aligned Q sample |
| out_valid | output | 1 | One-cycle strobe per emitted pair |
| rate_clk | output | 1 | Channel-rate clock / pair phase |

## Verification
The bench builds the block with DW=12. At that width the pin that borrows as port-B MSB sits at bit 11, and the codes 0x000, 0x7FF, 0x800 and 0xF00 exercise the sign-flip boundary of the format conversion. The vector table walks every steering option and ordering through paired, orphaned and repeated words. Directed steps cover a reset that lands between the two halves of a pair.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;

  // Action decided by the steering logic for the word(s) sampled this edge.
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,  // nothing captured (mode change)
    ACT_FIRST = 3'd1,  // leading word stored, waiting for partner
    ACT_PAIR  = 3'd2,  // trailing word completes a pair
    ACT_DROP  = 3'd3,  // trailing word without partner, discarded
    ACT_BOTH  = 3'd4   // dual-port: both words present at once
  } act_e;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/iq_fmt_conv.sv
module iq_fmt_conv #(
  parameter int unsigned DW    = 12,
  parameter int unsigned LANES = 2
) (
  input  logic                          to_twos,
  input  logic [LANES-1:0][DW-1:0]      raw,
  output logic [LANES-1:0][DW-1:0]      cooked
);

  localparam int unsigned MSB = DW - 1;

  // Offset binary and two's complement differ only in the sign bit.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cooked[g] = {raw[g][MSB] ^ to_twos, raw[g][MSB-1:0]};
  end

endmodule

// File: rtl/iq_pair_steer.sv
module iq_pair_steer
  import iq_demux_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic one_port,
  input  logic q_first,
  input  logic sel_inv,
  input  logic sel_internal,
  input  logic rclk_inv,
  input  logic sel_pin,
  output act_e act,
  output logic word_to_i,
  output logic rate_clk
);

  logic mode_prev;
  logic have_first;
  logic have_first_n;
  logic lead_is_i;
  logic is_lead;
  logic mode_chg;

  always_comb begin
    lead_is_i = ~q_first;
    mode_chg  = (one_port != mode_prev);
    if (sel_internal) begin
      word_to_i = have_first ? ~lead_is_i : lead_is_i;
    end else begin
      word_to_i = sel_pin ^ sel_inv;
    end
    is_lead = (word_to_i == lead_is_i);
  end

  always_comb begin
    act          = ACT_IDLE;
    have_first_n = 1'b0;
    if (mode_chg) begin
      act          = ACT_IDLE;
      have_first_n = 1'b0;
    end else if (!one_port) begin
      act          = ACT_BOTH;
      have_first_n = 1'b0;
    end else if (is_lead) begin
      act          = ACT_FIRST;
      have_first_n = 1'b1;
    end else if (have_first) begin
      act          = ACT_PAIR;
      have_first_n = 1'b0;
    end else begin
      act          = ACT_DROP;
      have_first_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_prev  <= one_port;
      have_first <= 1'b0;
      rate_clk   <= 1'b0;
    end else begin
      mode_prev  <= one_port;
      have_first <= have_first_n;
      rate_clk   <= (one_port ? ~have_first_n : 1'b1) ^ rclk_inv;
    end
  end

  AST_RCLK_DUAL_PORT: assert property (@(posedge clk) disable iff (rst)
    (!one_port) |=> (rate_clk == !$past(rclk_inv)));  // R9

  AST_RCLK_INTERNAL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (one_port && sel_internal && (one_port == mode_prev) && $past(one_port) &&
     $past(sel_internal) && $stable(rclk_inv) && !$past(rst))
    |=> (rate_clk != $past(rate_clk)));  // R7

endmodule

// File: rtl/iq_out_hold.sv
module iq_out_hold
  import iq_demux_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          one_port,
  input  act_e          act,
  input  logic          word_to_i,
  input  logic [DW-1:0] lane_a,
  input  logic [DW-1:0] lane_b,
  output logic [DW-1:0] i_out,
  output logic [DW-1:0] q_out,
  output logic          out_valid
);

  logic [DW-1:0] lead_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_word <= '0;
      i_out     <= '0;
      q_out     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= (act == ACT_PAIR) || (act == ACT_BOTH);
      case (act)
        ACT_FIRST: lead_word <= lane_a;
        ACT_PAIR: begin
          i_out <= word_to_i ? lane_a : lead_word;
          q_out <= word_to_i ? lead_word : lane_a;
        end
        ACT_BOTH: begin
          i_out <= lane_a;
          q_out <= lane_b;
        end
        default: ;
      endcase
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(i_out) && $stable(q_out)));  // R11

  AST_SHARED_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (one_port && $past(one_port) && out_valid) |-> !$past(out_valid));  // R3

  AST_DUAL_STREAMS: assert property (@(posedge clk) disable iff (rst)
    (!one_port && !$past(one_port)) |=> out_valid);  // R2

  AST_MODE_CHANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (one_port != $past(one_port)) |=> !out_valid);  // R10

endmodule

// File: rtl/iq_port_demux.sv
module iq_port_demux
  import iq_demux_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_one_port,
  input  logic          cfg_q_first,
  input  logic          cfg_sel_inv,
  input  logic          cfg_sel_internal,
  input  logic          cfg_unsigned,
  input  logic          cfg_rclk_inv,
  input  logic [DW-1:0] port_a,
  input  logic [DW-2:0] port_b_lo,
  input  logic          sel_b_msb,
  output logic [DW-1:0] i_out,
  output logic [DW-1:0] q_out,
  output logic          out_valid,
  output logic          rate_clk
);

  logic [LANES-1:0][DW-1:0] raw_lane;
  logic [LANES-1:0][DW-1:0] twos_lane;
  act_e                     act;
  logic                     word_to_i;

  assign raw_lane[0] = port_a;
  assign raw_lane[1] = {sel_b_msb, port_b_lo};

  iq_fmt_conv #(
    .DW   (DW),
    .LANES(LANES)
  ) u_fmt (
    .to_twos(cfg_unsigned),
    .raw    (raw_lane),
    .cooked (twos_lane)
  );

  iq_pair_steer u_steer (
    .clk         (clk),
    .rst         (rst),
    .one_port    (cfg_one_port),
    .q_first     (cfg_q_first),
    .sel_inv     (cfg_sel_inv),
    .sel_internal(cfg_sel_internal),
    .rclk_inv    (cfg_rclk_inv),
    .sel_pin     (sel_b_msb),
    .act         (act),
    .word_to_i   (word_to_i),
    .rate_clk    (rate_clk)
  );

  iq_out_hold #(
    .DW(DW)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .one_port (cfg_one_port),
    .act      (act),
    .word_to_i(word_to_i),
    .lane_a   (twos_lane[0]),
    .lane_b   (twos_lane[1]),
    .i_out    (i_out),
    .q_out    (q_out),
    .out_valid(out_valid)
  );

endmodule

// File: tb/iq_port_demux_bench.sv
`timescale 1ns/1ps
module iq_port_demux_bench;

  localparam int unsigned DW = 12;
  localparam int unsigned NV = 29;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_one_port, cfg_q_first, cfg_sel_inv;
  logic          cfg_sel_internal, cfg_unsigned, cfg_rclk_inv;
  logic [DW-1:0] port_a;
  logic [DW-2:0] port_b_lo;
  logic          sel_b_msb;
  logic [DW-1:0] i_out, q_out;
  logic          out_valid, rate_clk;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  iq_port_demux #(.DW(DW)) u_iq_port_demux (
    .clk(clk), .rst(rst),
    .cfg_one_port(cfg_one_port), .cfg_q_first(cfg_q_first),
    .cfg_sel_inv(cfg_sel_inv), .cfg_sel_internal(cfg_sel_internal),
    .cfg_unsigned(cfg_unsigned), .cfg_rclk_inv(cfg_rclk_inv),
    .port_a(port_a), .port_b_lo(port_b_lo), .sel_b_msb(sel_b_msb),
    .i_out(i_out), .q_out(q_out), .out_valid(out_valid), .rate_clk(rate_clk)
  );

  // cfg bits: one_port, q_first, sel_inv, sel_internal, unsigned, rclk_inv
  // fields: cfg, port_a, sel, port_b_lo, exp_valid, exp_i, exp_q, exp_rclk
  localparam logic [55:0] VEC [NV] = '{
    {6'b000000, 12'h123, 1'b0, 11'h456, 1'b1, 12'h123, 12'h456, 1'b1},
    {6'b000000, 12'h7FF, 1'b1, 11'h001, 1'b1, 12'h7FF, 12'h801, 1'b1},
    {6'b000010, 12'h000, 1'b1, 11'h000, 1'b1, 12'h800, 12'h000, 1'b1},
    {6'b000001, 12'hABC, 1'b0, 11'h123, 1'b1, 12'hABC, 12'h123, 1'b0},
    {6'b100000, 12'h111, 1'b1, 11'h000, 1'b0, 12'hABC, 12'h123, 1'b1},
    {6'b100000, 12'h111, 1'b1, 11'h000, 1'b0, 12'hABC, 12'h123, 1'b0},
    {6'b100000, 12'h222, 1'b0, 11'h000, 1'b1, 12'h111, 12'h222, 1'b1},
    {6'b100000, 12'h333, 1'b0, 11'h000, 1'b0, 12'h111, 12'h222, 1'b1},
    {6'b100000, 12'h444, 1'b1, 11'h000, 1'b0, 12'h111, 12'h222, 1'b0},
    {6'b100000, 12'h555, 1'b1, 11'h000, 1'b0, 12'h111, 12'h222, 1'b0},
    {6'b100000, 12'h666, 1'b0, 11'h000, 1'b1, 12'h555, 12'h666, 1'b1},
    {6'b101000, 12'h777, 1'b0, 11'h000, 1'b0, 12'h555, 12'h666, 1'b0},
    {6'b101000, 12'h888, 1'b1, 11'h000, 1'b1, 12'h777, 12'h888, 1'b1},
    {6'b110000, 12'h999, 1'b1, 11'h000, 1'b0, 12'h777, 12'h888, 1'b1},
    {6'b110000, 12'hAAA, 1'b0, 11'h000, 1'b0, 12'h777, 12'h888, 1'b0},
    {6'b110000, 12'hBBB, 1'b1, 11'h000, 1'b1, 12'hBBB, 12'hAAA, 1'b1},
    {6'b100100, 12'h0C1, 1'b0, 11'h000, 1'b0, 12'hBBB, 12'hAAA, 1'b0},
    {6'b100100, 12'h0C2, 1'b0, 11'h000, 1'b1, 12'h0C1, 12'h0C2, 1'b1},
    {6'b110111, 12'hF00, 1'b1, 11'h000, 1'b0, 12'h0C1, 12'h0C2, 1'b1},
    {6'b110111, 12'h0FF, 1'b1, 11'h000, 1'b1, 12'h8FF, 12'h700, 1'b0},
    {6'b000000, 12'h111, 1'b0, 11'h000, 1'b0, 12'h8FF, 12'h700, 1'b1},
    {6'b000000, 12'h5A5, 1'b1, 11'h25A, 1'b1, 12'h5A5, 12'hA5A, 1'b1},
    {6'b100000, 12'h000, 1'b0, 11'h000, 1'b0, 12'h5A5, 12'hA5A, 1'b1},
    {6'b100000, 12'h321, 1'b1, 11'h000, 1'b0, 12'h5A5, 12'hA5A, 1'b0},
    {6'b000000, 12'h000, 1'b0, 11'h000, 1'b0, 12'h5A5, 12'hA5A, 1'b1},
    {6'b100000, 12'h000, 1'b0, 11'h000, 1'b0, 12'h5A5, 12'hA5A, 1'b1},
    {6'b100000, 12'h0AA, 1'b0, 11'h000, 1'b0, 12'h5A5, 12'hA5A, 1'b1},
    {6'b100000, 12'h0BB, 1'b1, 11'h000, 1'b0, 12'h5A5, 12'hA5A, 1'b0},
    {6'b100000, 12'h0CC, 1'b0, 11'h000, 1'b1, 12'h0BB, 12'h0CC, 1'b1}
  };

  function automatic string tag_of(input int idx);
    case (idx)
      0, 1, 21:          return "R2";
      2, 18, 19:         return "R8";
      3:                 return "R9";
      4, 20:             return "R10";
      5, 6:              return "R3";
      7, 13, 14, 15:     return "R5";
      8, 9, 10:          return "R6";
      11, 12:            return "R4";
      16, 17:            return "R7";
      default:           return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [5:0] cfg, input logic [DW-1:0] a,
                       input logic sel, input logic [DW-2:0] blo);
    {cfg_one_port, cfg_q_first, cfg_sel_inv,
     cfg_sel_internal, cfg_unsigned, cfg_rclk_inv} = cfg;
    port_a    = a;
    sel_b_msb = sel;
    port_b_lo = blo;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(6'b000000, '0, 1'b0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "i_out", i_out, 0);
    chk("R1", "q_out", q_out, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "rate_clk", rate_clk, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][55:50], VEC[v][49:38], VEC[v][37], VEC[v][36:26]);
      step();
      chk(tag_of(v), "i_out", i_out, VEC[v][24:13]);
      chk(tag_of(v), "q_out", q_out, VEC[v][12:1]);
      chk("R11", "out_valid", out_valid, VEC[v][25]);
      chk("R9", "rate_clk", rate_clk, VEC[v][0]);
    end

    // R1: reset landing between the halves of a pair
    drive(6'b100000, 12'h0DD, 1'b1, '0);
    step();
    chk("R3", "rate_clk", rate_clk, 0);
    rst = 1'b1;
    drive(6'b100000, 12'h0DE, 1'b0, '0);
    step();
    step();
    chk("R1", "i_out", i_out, 0);
    chk("R1", "q_out", q_out, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "rate_clk", rate_clk, 0);
    rst = 1'b0;
    // trailing word right after reset has no partner: dropped
    drive(6'b100000, 12'h0EE, 1'b0, '0);
    step();
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "i_out", i_out, 0);
    chk("R1", "q_out", q_out, 0);
    drive(6'b100000, 12'h0F1, 1'b1, '0);
    step();
    drive(6'b100000, 12'h0F2, 1'b0, '0);
    step();
    chk("R3", "out_valid", out_valid, 1);
    chk("R3", "i_out", i_out, 12'h0F1);
    chk("R3", "q_out", q_out, 12'h0F2);
    step();
    chk("R11", "out_valid", out_valid, 0);
    chk("R11", "i_out", i_out, 12'h0F1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule